// File: doc/BRIEF.md
# Four-Channel Double-Buffered Pulse-Width Modulator

The block drives four rectangular outputs, each from its own prescaler and step counter. A host programs each channel through a plain register port with write and read strobes, an 8-bit byte address and 32-bit data. A channel's output rises at the start of every period. It stays high for a programmed number of steps and then stays low until the period ends. The prescaler sets how many clock cycles make up one step.

The period length and the high time are double-buffered. Writes to the modulus and duty registers land in staging registers that the host can read back. Writing the duty register arms a commit. The running period always completes with its old settings, and the armed values take over at the next period boundary. This means a period never mixes old and new values. Clearing the enable bit stops the channel in the next cycle. Setting it again restarts the channel from the beginning of a period.

The register port is a control path with no flow control. A write takes effect at the clock edge where `wr_en` is high. Read data is registered and is valid in the cycle after `rd_en`. The outputs are level signals with no handshake.

Top module: `mchan_pwm`

## Requirements
- R1: Address decode. Bit 7 of the address must be 0. Bits 6:5 select the channel. Bits 4:0 select the register: 0x00 is the 8-bit prescale, 0x04 the 8-bit modulus, 0x08 the 16-bit duty and 0x18 the enable in bit 0. Writing one channel leaves the registers of every other channel unchanged.
- R2: A read returns the last value written to the addressed register, truncated to that register's width, with all other bits zero. `rdata` changes at the clock edge where `rd_en` is high and is sampled in the following cycle.
- R3: An address that matches no register reads as zero. A write to such an address changes no register.
- R4: Let P be the active prescale, M the active modulus and D the active duty. A period lasts (P+1)·M clock cycles. The output is high for the first (P+1)·D cycles of each period.
- R5: A duty of 0 gives a constant low output. A duty equal to or greater than the modulus gives a constant high output.
- R6: Modulus and duty writes are staged. A duty write arms a commit. While the channel runs, the armed values become active only at the next period boundary. A modulus write with no later duty write never takes effect.
- R7: Writing 0 to the enable bit forces the output low from the next cycle, without finishing the period. While the channel is disabled, its counters are held at zero.
- R8: Writing 1 to the enable bit of an idle channel starts a new period in the next cycle. The start applies any armed commit immediately. With no armed commit, the channel uses its last active values.
- R9: After reset, all registers read 0 and all outputs are low.
- R10: Channels run independently. Configuring one channel does not disturb the output waveform of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address (channel and register offset) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle after `rd_en` |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The bench stages a new modulus in the middle of a period and then commits it later. A design that applied staged values at once would wrap early and produce a visible extra pulse inside the first period. It disables a channel while its output is high and checks for a low output in the next cycle. A design that waited for the period to end would keep the pulse going. The bench also covers a duty of zero, a duty above the modulus, a modulus of one, and writes to unmapped addresses that alias a real register in their low bits. A decoder that ignored the upper address bit would overwrite the prescale of channel 0.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [7:0] OFF_PRE  = 8'h00;
  localparam logic [7:0] OFF_MOD  = 8'h04;
  localparam logic [7:0] OFF_DUTY = 8'h08;
  localparam logic [7:0] OFF_EN   = 8'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRE,
    SEL_MOD,
    SEL_DUTY,
    SEL_EN
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [7:0] off);
    case (off)
      OFF_PRE:  return SEL_PRE;
      OFF_MOD:  return SEL_MOD;
      OFF_DUTY: return SEL_DUTY;
      OFF_EN:   return SEL_EN;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [PRE_W-1:0]  pre_q,
  output logic [MOD_W-1:0]  mod_q,
  output logic [DUTY_W-1:0] duty_q,
  output logic              en_q,
  output logic              duty_wr,
  output logic              start
);
  logic wr_pre, wr_mod, wr_en_bit;

  assign wr_pre    = wr && (sel == SEL_PRE);
  assign wr_mod    = wr && (sel == SEL_MOD);
  assign duty_wr   = wr && (sel == SEL_DUTY);
  assign wr_en_bit = wr && (sel == SEL_EN);
  assign start     = wr_en_bit && wdata[0] && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      mod_q  <= '0;
      duty_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_pre)    pre_q  <= wdata[PRE_W-1:0];
      if (wr_mod)    mod_q  <= wdata[MOD_W-1:0];
      if (duty_wr)   duty_q <= wdata[DUTY_W-1:0];
      if (wr_en_bit) en_q   <= wdata[0];
    end
  end

  // R6
  stage_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_q) |-> $past(wr && (sel == SEL_MOD)));

  // R3
  duty_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_q) |-> $past(duty_wr));
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              duty_wr,
  input  logic [PRE_W-1:0]  pre_in,
  input  logic [MOD_W-1:0]  mod_in,
  input  logic [DUTY_W-1:0] duty_in,
  output logic              out
);
  localparam int CMP_W = MOD_W + 1;

  logic [PRE_W-1:0]  pre_act, pcnt;
  logic [MOD_W-1:0]  mod_act, scnt;
  logic [DUTY_W-1:0] duty_act;
  logic              pending;
  logic              tick, wrap, load, commit;

  assign tick   = en && (pcnt == pre_act);
  assign wrap   = tick && ((CMP_W'(scnt) + CMP_W'(1)) >= CMP_W'(mod_act));
  assign load   = start || wrap;
  assign commit = load && pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      scnt <= '0;
    end else if (!en) begin
      pcnt <= '0;
      scnt <= '0;
    end else if (tick) begin
      pcnt <= '0;
      scnt <= wrap ? '0 : scnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_act  <= '0;
      mod_act  <= '0;
      duty_act <= '0;
      pending  <= 1'b0;
    end else begin
      if (load) pre_act <= pre_in;
      if (commit) begin
        mod_act  <= mod_in;
        duty_act <= duty_in;
      end
      if (duty_wr)     pending <= 1'b1;
      else if (commit) pending <= 1'b0;
    end
  end

  assign out = en && (duty_act > DUTY_W'(scnt));

  // R7
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pcnt == '0 && scnt == '0));

  // R6
  act_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mod_act) || !$stable(duty_act)) |-> (pcnt == '0 && scnt == '0));

  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mod_act != '0) |-> (scnt < mod_act));

  // R4
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pcnt <= pre_act));
endmodule

// File: rtl/mchan_pwm.sv
module mchan_pwm
  import pwm_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int PRE_W    = 8,
  parameter int MOD_W    = 8,
  parameter int DUTY_W   = 16,
  parameter int CH_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CH_SHIFT-1:0] off;
  logic [CHW-1:0]      ch;
  logic                in_range;
  reg_sel_e            sel;
  logic [DATA_W-1:0]   rd_val;

  logic [PRE_W-1:0]  pre_a  [NCH];
  logic [MOD_W-1:0]  mod_a  [NCH];
  logic [DUTY_W-1:0] duty_a [NCH];
  logic              en_a   [NCH];

  assign off      = addr[CH_SHIFT-1:0];
  assign ch       = addr[CH_SHIFT+CHW-1:CH_SHIFT];
  assign in_range = ((addr >> (CH_SHIFT + CHW)) == '0) && (int'(ch) < NCH);
  assign sel      = in_range ? decode_off(8'(off)) : SEL_NONE;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_i, duty_wr_i, start_i;
    assign wr_i = wr_en && (ch == CHW'(i)) && (sel != SEL_NONE);

    pwm_chan_regs #(
      .DATA_W(DATA_W), .PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)
    ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(wr_i), .sel(sel), .wdata(wdata),
      .pre_q(pre_a[i]), .mod_q(mod_a[i]), .duty_q(duty_a[i]), .en_q(en_a[i]),
      .duty_wr(duty_wr_i), .start(start_i)
    );

    pwm_chan_core #(
      .PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)
    ) core_i (
      .clk(clk), .rst_n(rst_n), .en(en_a[i]), .start(start_i),
      .duty_wr(duty_wr_i), .pre_in(pre_a[i]), .mod_in(mod_a[i]),
      .duty_in(duty_a[i]), .out(pwm_out[i])
    );
  end

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_PRE:  rd_val = DATA_W'(pre_a[ch]);
      SEL_MOD:  rd_val = DATA_W'(mod_a[ch]);
      SEL_DUTY: rd_val = DATA_W'(duty_a[ch]);
      SEL_EN:   rd_val = DATA_W'(en_a[ch]);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  // R3
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_range) |=> (rdata == '0));
endmodule

// File: tb/mchan_pwm_tb_top.sv
module mchan_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mchan_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  // fields: ch, prescale, modulus, duty(16), expected high cycles in one period
  localparam logic [47:0] VEC [6] = '{
    {8'd0, 8'd0, 8'd10, 16'd3,   8'd3},
    {8'd1, 8'd2, 8'd5,  16'd2,   8'd6},
    {8'd2, 8'd1, 8'd8,  16'd8,   8'd16},
    {8'd3, 8'd0, 8'd6,  16'd0,   8'd0},
    {8'd0, 8'd3, 8'd4,  16'd300, 8'd16},
    {8'd1, 8'd0, 8'd1,  16'd1,   8'd1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [7:0] cb;
    int hi, per, ind_bad;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    chk("R9 outputs", 32'(pwm_out), 32'h0);
    chk("R9 rdata", rdata, 32'h0);
    rd(8'h18, d); chk("R9 enable reg", d, 32'h0);
    rd(8'h64, d); chk("R9 modulus reg", d, 32'h0);

    // R1 / R2 readback with truncation
    wr(8'h00, 32'h1FF);   rd(8'h00, d); chk("R2 prescale trunc", d, 32'hFF);
    rd(8'h20, d);         chk("R1 other channel untouched", d, 32'h0);
    wr(8'h44, 32'hABC);   rd(8'h44, d); chk("R2 modulus trunc", d, 32'hBC);
    wr(8'h68, 32'h12345); rd(8'h68, d); chk("R2 duty trunc", d, 32'h2345);
    wr(8'h78, 32'hFE);    rd(8'h78, d); chk("R2 enable bit0 only", d, 32'h0);
    wr(8'h78, 32'h3);     rd(8'h78, d); chk("R1 enable offset", d, 32'h1);

    // R3 unmapped addresses
    wr(8'h80, 32'h77);    rd(8'h00, d); chk("R3 aliased write ignored", d, 32'hFF);
    rd(8'h80, d);         chk("R3 high-bit read zero", d, 32'h0);
    wr(8'h0C, 32'h55);    rd(8'h0C, d); chk("R3 hole reads zero", d, 32'h0);

    // R4 R5 R8 table: staged while idle, committed at start
    foreach (VEC[v]) begin
      cb = VEC[v][47:40] << 5;
      wr(cb | 8'h18, 32'h0);
      wr(cb | 8'h00, 32'(VEC[v][39:32]));
      wr(cb | 8'h04, 32'(VEC[v][31:24]));
      wr(cb | 8'h08, 32'(VEC[v][23:8]));
      wr(cb | 8'h18, 32'h1);
      per = (int'(VEC[v][39:32]) + 1) * int'(VEC[v][31:24]);
      hi = 0;
      for (int k = 0; k < per; k++) begin
        if (pwm_out[VEC[v][41:40]]) hi++;
        @(negedge clk);
      end
      chk("R4/R5/R8 high cycles", 32'(hi), 32'(VEC[v][7:0]));
      chk("R4 next period start", 32'(pwm_out[VEC[v][41:40]]),
          32'(VEC[v][23:8] != 16'd0));
    end

    // R6 shadowing on ch0, plus R10 independence of ch1/ch2/ch3
    wr(8'h18, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'd10);
    wr(8'h08, 32'd3);
    wr(8'h18, 32'h1);
    ind_bad = 0;
    for (int c = 0; c < 30; c++) begin
      chk("R6 staged commit at boundary", 32'(pwm_out[0]),
          32'((c < 10) ? (c < 3) : (((c - 10) % 4) < 2)));
      if (pwm_out[3:1] !== 3'b011) ind_bad++;
      if (c == 4)      begin wr_en = 1'b1; addr = 8'h04; wdata = 32'd4; end
      else if (c == 6) begin wr_en = 1'b1; addr = 8'h08; wdata = 32'd2; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk("R10 other channels undisturbed", 32'(ind_bad), 32'h0);

    // R7 immediate stop, R8 restart with last active values
    wr(8'h38, 32'h0);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'd10);
    wr(8'h28, 32'd8);
    wr(8'h38, 32'h1);
    for (int c = 0; c < 22; c++) begin
      chk((c >= 3 && c < 7) ? "R7 disable immediate" : "R8 restart from zero",
          32'(pwm_out[1]),
          32'((c < 3) ? 1 : (c < 7) ? 0 : (((c - 7) % 10) < 8)));
      if (c == 2)      begin wr_en = 1'b1; addr = 8'h38; wdata = 32'h0; end
      else if (c == 6) begin wr_en = 1'b1; addr = 8'h38; wdata = 32'h1; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;

    // R6 modulus write without duty write never applies
    wr(8'h24, 32'd3);
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      if (pwm_out[1]) hi++;
      @(negedge clk);
    end
    chk("R6 uncommitted modulus ignored", 32'(hi), 32'd16);

    finish_run();
  end
endmodule